// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block gathers level-sensitive request lines from a group of devices, such as a timer or a network port, plus one request bit that software sets. It gives the processor a single interrupt signal together with an identity code for the source to be serviced. Each maskable source passes through its own enable bit. A priority encoder picks the winning source. A processor-side global disable input silences every maskable source at once. A separate non-maskable line passes through regardless of the enable bits and the global disable.

Software reaches the block through a small write port. Address 0 holds the enable register. Address 1 is the software request control, where data bit 0 sets the request and data bit 1 clears it. An acknowledge pulse from the processor retires the software request when that request is the one being reported. The interrupt and identity outputs are combinational in the request inputs, so they follow the request lines in the same cycle.

Top module: `irq_arbiter`

## Requirements
- R1: After reset the enable register is all zero and the software request is clear, so device requests alone give `irq_o`=0 and `irq_id_o`=0.
- R2: Source i (device line i for i < NUM_DEV, software request for i = NUM_DEV) is eligible only while enable bit i is 1. Enable bit i is bit i of the data written at address 0.
- R3: Among eligible sources the lowest index wins, and `irq_id_o` carries that index. The software request has index NUM_DEV and so the lowest maskable priority.
- R4: A write to address 1 with data bit 0 set raises the software request, and data bit 1 set clears it. When both bits are set the clear wins. The request persists until it is cleared or acknowledged.
- R5: While `gdis_i` is 1 and `nmi_i` is 0, `irq_o` is 0 whatever the maskable requests are.
- R6: While `nmi_i` is 1, `irq_o`=1, `irq_nmi_o`=1 and `irq_id_o` is all ones, regardless of the enable register, `gdis_i` and any other request.
- R7: `irq_o` and `irq_id_o` follow changes of `dev_req_i`, `nmi_i` and `gdis_i` in the same cycle, with no register stage. While `irq_o` is 0, `irq_id_o` is 0.
- R8: Device lines are level-sensitive. `ack_i` does not clear them, and a held line keeps being reported after an acknowledge.
- R9: `ack_i` clears the software request only in a cycle where the software source is the one reported, with `irq_id_o`=NUM_DEV. Otherwise the request is kept. A set in the same cycle wins over the acknowledge.
- R10: A write to the enable register takes effect at the clock edge that accepts it. During the write cycle the previous enable value still governs the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_req_i | input | NUM_DEV | Level request lines from devices, line 0 first |
| nmi_i | input | 1 | Non-maskable request |
| gdis_i | input | 1 | Processor global disable of maskable sources |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = enable register, 1 = software request control |
| wr_data_i | input | NUM_DEV+1 | Write data |
| ack_i | input | 1 | Acknowledge of the reported interrupt |
| irq_o | output | 1 | Interrupt to the processor |
| irq_id_o | output | clog2(NUM_DEV+2) | Identity of the reported source; all ones for the non-maskable line |
| irq_nmi_o | output | 1 | The reported interrupt is the non-maskable one |

## Verification
On every cycle the assertions check the following: the non-maskable line wins with its reserved code, global disable silences maskable sources, at most one source is granted, a reported code lies in range, and the software request reacts to set, clear and acknowledge. Only the directed scenarios can show the rest. These are the exact winner for chosen request and enable patterns, the lowest-priority position of the software source, the one-cycle delay of enable writes, and the fact that an acknowledge leaves held device lines and an unserved software request in place.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic {
        REG_ENABLE = 1'b0,
        REG_SWCTL  = 1'b1
    } irq_reg_e;

    localparam int SWCTL_SET_BIT = 0;
    localparam int SWCTL_CLR_BIT = 1;

    typedef struct packed {
        logic set;
        logic clr;
    } swi_cmd_t;

endpackage

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
#(
    parameter int N = 5
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         wr_en_i,
    input  logic         wr_addr_i,
    input  logic [N-1:0] wr_data_i,
    input  logic         ack_sw_i,
    output logic [N-1:0] enable_o,
    output logic         swi_o
);

    typedef struct packed {
        logic [N-1:0] enable;
        logic         swi;
    } regs_t;

    regs_t    st_d, st_q;
    swi_cmd_t cmd;

    always_comb begin
        st_d    = st_q;
        cmd.set = wr_en_i && (irq_reg_e'(wr_addr_i) == REG_SWCTL) && wr_data_i[SWCTL_SET_BIT];
        cmd.clr = wr_en_i && (irq_reg_e'(wr_addr_i) == REG_SWCTL) && wr_data_i[SWCTL_CLR_BIT];
        if (wr_en_i && (irq_reg_e'(wr_addr_i) == REG_ENABLE)) begin
            st_d.enable = wr_data_i;
        end
        // priority: clear, then set, then acknowledge
        if (cmd.clr) begin
            st_d.swi = 1'b0;
        end else if (cmd.set) begin
            st_d.swi = 1'b1;
        end else if (ack_sw_i) begin
            st_d.swi = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign enable_o = st_q.enable;
    assign swi_o    = st_q.swi;

    p_swi_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd.clr |=> !swi_o);

    p_swi_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd.set && !cmd.clr) |=> swi_o);

    p_swi_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_sw_i && !cmd.set) |=> !swi_o);

    p_swi_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (swi_o && !ack_sw_i && !cmd.clr) |=> swi_o);

    p_enable_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_addr_i) |=> (enable_o == $past(wr_data_i)));

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N    = 5,
    parameter int ID_W = 3
) (
    input  logic [N-1:0]    elig_i,
    output logic [N-1:0]    grant_o,
    output logic            any_o,
    output logic [ID_W-1:0] id_o
);

    logic [N:0] blocked;

    assign blocked[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_chain
            assign grant_o[g]   = elig_i[g] & ~blocked[g];
            assign blocked[g+1] = blocked[g] | elig_i[g];
        end
    endgenerate

    assign any_o = blocked[N];

    always_comb begin
        id_o = '0;
        for (int i = 0; i < N; i++) begin
            if (grant_o[i]) begin
                id_o = id_o | ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter  int NUM_DEV = 4,
    localparam int N       = NUM_DEV + 1,
    localparam int ID_W    = $clog2(N + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_DEV-1:0] dev_req_i,
    input  logic               nmi_i,
    input  logic               gdis_i,
    input  logic               wr_en_i,
    input  logic               wr_addr_i,
    input  logic [N-1:0]       wr_data_i,
    input  logic               ack_i,
    output logic               irq_o,
    output logic [ID_W-1:0]    irq_id_o,
    output logic               irq_nmi_o
);

    localparam int              SW_IDX = NUM_DEV;
    localparam logic [ID_W-1:0] NMI_ID = '1;

    logic [N-1:0]    enable_q;
    logic            swi_q;
    logic [N-1:0]    pend;
    logic [N-1:0]    elig;
    logic [N-1:0]    grant;
    logic            any_mask;
    logic [ID_W-1:0] enc_id;
    logic            ack_sw;

    assign pend = {swi_q, dev_req_i};
    assign elig = pend & enable_q & {N{~gdis_i}};

    irq_prio_enc #(
        .N    (N),
        .ID_W (ID_W)
    ) u_enc (
        .elig_i  (elig),
        .grant_o (grant),
        .any_o   (any_mask),
        .id_o    (enc_id)
    );

    assign ack_sw = ack_i & ~nmi_i & grant[SW_IDX];

    irq_regs #(
        .N (N)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .ack_sw_i  (ack_sw),
        .enable_o  (enable_q),
        .swi_o     (swi_q)
    );

    always_comb begin
        irq_nmi_o = nmi_i;
        irq_o     = nmi_i | any_mask;
        irq_id_o  = nmi_i ? NMI_ID : enc_id;
    end

    p_nmi_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nmi_i |-> (irq_o && irq_nmi_o && irq_id_o == NMI_ID));

    p_gdis_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gdis_i && !nmi_i) |-> !irq_o);

    p_one_grant_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grant));

    p_id_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !nmi_i) |-> (int'(irq_id_o) < N));

    p_idle_id_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_o |-> (irq_id_o == '0));

endmodule

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;

    localparam int NUM_DEV = 4;
    localparam int N       = NUM_DEV + 1;
    localparam int ID_W    = 3;
    localparam logic [ID_W-1:0] NMI_ID = 3'd7;
    localparam logic [ID_W-1:0] SW_ID  = 3'd4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_DEV-1:0] dev_req = '0;
    logic               nmi = 1'b0;
    logic               gdis = 1'b0;
    logic               wr_en = 1'b0;
    logic               wr_addr = 1'b0;
    logic [N-1:0]       wr_data = '0;
    logic               ack = 1'b0;
    logic               irq;
    logic [ID_W-1:0]    irq_id;
    logic               irq_nmi;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_arbiter #(.NUM_DEV(NUM_DEV)) uut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .dev_req_i (dev_req),
        .nmi_i     (nmi),
        .gdis_i    (gdis),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .ack_i     (ack),
        .irq_o     (irq),
        .irq_id_o  (irq_id),
        .irq_nmi_o (irq_nmi)
    );

    task automatic chk(input string req, input logic e_irq, input logic [ID_W-1:0] e_id,
                       input logic e_nmi);
        #1;
        checks++;
        if (irq !== e_irq || irq_id !== e_id || irq_nmi !== e_nmi) begin
            errors++;
            $display("FAIL %s: irq/id/nmi actual %0b/%0d/%0b expected %0b/%0d/%0b",
                     req, irq, irq_id, irq_nmi, e_irq, e_id, e_nmi);
        end
    endtask

    task automatic wr(input logic a, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        settle(); dev_req = 4'b1111;
        chk("R1 reset masks devices", 1'b0, 3'd0, 1'b0);
        nmi = 1'b1;
        chk("R6 nmi after reset", 1'b1, NMI_ID, 1'b1);
        nmi = 1'b0; dev_req = '0;
    endtask

    task automatic t_mask();
        wr(1'b0, 5'b00100);
        dev_req = 4'b1111;
        chk("R2 only line 2 enabled", 1'b1, 3'd2, 1'b0);
        // R10: during the write cycle the old enable value governs
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 1'b0; wr_data = 5'b01010;
        chk("R10 old enable during write", 1'b1, 3'd2, 1'b0);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R10 new enable after edge", 1'b1, 3'd1, 1'b0);
        dev_req = 4'b1000;
        chk("R2 line 3 enabled", 1'b1, 3'd3, 1'b0);
        dev_req = 4'b0101;
        chk("R2 masked lines ignored", 1'b0, 3'd0, 1'b0);
        dev_req = '0;
    endtask

    task automatic t_priority();
        wr(1'b0, 5'b11111);
        dev_req = 4'b1111;
        chk("R3 line 0 highest", 1'b1, 3'd0, 1'b0);
        dev_req = 4'b1100;
        chk("R3 line 2 over 3", 1'b1, 3'd2, 1'b0);
        wr(1'b1, 5'b00001);
        dev_req = 4'b1000;
        chk("R3 device over software", 1'b1, 3'd3, 1'b0);
        dev_req = 4'b0000;
        chk("R7 software reported same cycle", 1'b1, SW_ID, 1'b0);
        wr(1'b1, 5'b00010);
    endtask

    task automatic t_swi();
        wr(1'b1, 5'b00001);
        chk("R4 software set", 1'b1, SW_ID, 1'b0);
        repeat (3) settle();
        chk("R4 software persists", 1'b1, SW_ID, 1'b0);
        wr(1'b1, 5'b00010);
        chk("R4 software clear", 1'b0, 3'd0, 1'b0);
        wr(1'b1, 5'b00001);
        wr(1'b1, 5'b00011);
        chk("R4 clear wins over set", 1'b0, 3'd0, 1'b0);
        wr(1'b0, 5'b01111);
        wr(1'b1, 5'b00001);
        chk("R2 software masked", 1'b0, 3'd0, 1'b0);
        wr(1'b0, 5'b11111);
        chk("R2 software enabled", 1'b1, SW_ID, 1'b0);
        wr(1'b1, 5'b00010);
    endtask

    task automatic t_gdis();
        settle();
        dev_req = 4'b1111; gdis = 1'b1;
        chk("R5 global disable", 1'b0, 3'd0, 1'b0);
        nmi = 1'b1;
        chk("R6 nmi ignores global disable", 1'b1, NMI_ID, 1'b1);
        nmi = 1'b0; gdis = 1'b0;
        chk("R7 release of global disable", 1'b1, 3'd0, 1'b0);
        dev_req = '0;
    endtask

    task automatic t_nmi();
        settle();
        dev_req = 4'b0001; nmi = 1'b1;
        chk("R6 nmi outranks line 0", 1'b1, NMI_ID, 1'b1);
        wr(1'b0, 5'b00000);
        chk("R6 nmi ignores enable", 1'b1, NMI_ID, 1'b1);
        nmi = 1'b0;
        chk("R7 nmi drop", 1'b0, 3'd0, 1'b0);
        wr(1'b0, 5'b11111);
        dev_req = '0;
    endtask

    task automatic t_ack();
        wr(1'b1, 5'b00001);
        chk("R9 software before ack", 1'b1, SW_ID, 1'b0);
        pulse_ack();
        chk("R9 ack clears software", 1'b0, 3'd0, 1'b0);
        wr(1'b1, 5'b00001);
        dev_req = 4'b0001;
        pulse_ack();
        chk("R8 held line after ack", 1'b1, 3'd0, 1'b0);
        dev_req = 4'b0000;
        chk("R9 unserved software kept", 1'b1, SW_ID, 1'b0);
        nmi = 1'b1;
        pulse_ack();
        nmi = 1'b0;
        chk("R9 ack under nmi keeps software", 1'b1, SW_ID, 1'b0);
        @(negedge clk);
        ack = 1'b1; wr_en = 1'b1; wr_addr = 1'b1; wr_data = 5'b00001;
        @(negedge clk);
        ack = 1'b0; wr_en = 1'b0; wr_data = '0;
        chk("R9 set wins over ack", 1'b1, SW_ID, 1'b0);
        wr(1'b1, 5'b00010);
        dev_req = 4'b0010;
        pulse_ack();
        chk("R8 level line survives ack", 1'b1, 3'd1, 1'b0);
        dev_req = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask();
        t_priority();
        t_swi();
        t_gdis();
        t_nmi();
        t_ack();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule